// File: doc/BRIEF.md
# Multiplexed Converter Serial Frame Master

This block runs the serial side of an eight-channel, 12-bit converter that answers in fixed 16-clock frames. A request on the parallel side gives a start pulse and a 3-bit channel number. The master then pulls chip select low and produces a serial clock from the system clock through a half-period divider. It shifts a command word out on the command line and shifts the reply in from the return line. At the end of each frame it presents the 12-bit result with a one-cycle valid pulse.

The converter pipelines its work: the address written during one frame picks the channel converted in the next. The word read back during that same frame is the conversion asked for in the frame before. The master therefore tags each result with the channel it sent one frame earlier, and it checks the four zero bits that lead every reply. With the continuous input held high, frames run back to back with chip select kept low. A stop pulse ends the run once the frame in flight has completed.

Top module: `adc_frame_master`

## Requirements
- R1: After reset and while idle, cs_n is 1, sclk is 1, cmd is 0, busy is 0 and res_valid is 0.
- R2: A start pulse while idle drives cs_n low. A frame is 16 serial clock cycles, each made of a low half followed by a high half. In single mode cs_n returns high at the end of the 16th high half and busy follows cs_n.
- R3: Each low half and each high half of sclk lasts exactly max(div_half, 1) system clocks, which gives a 50% duty cycle. div_half is sampled when a run starts from idle.
- R4: cmd carries 16 bits per frame, one per serial cycle, and changes only at a falling sclk edge or at frame start. Cycles 2, 3 and 4 (counting from 0) carry the channel bits, most significant first. All other cycles carry 0.
- R5: ret is sampled at each rising sclk edge. Of the 16 bits sampled, bits 4 to 15 form res_data, most significant first.
- R6: frame_err, valid with res_valid, is 1 when any of the first four sampled bits of the frame is 1, and 0 otherwise.
- R7: res_chan equals the channel sent in the previous frame. For the first frame after reset it is 0.
- R8: res_valid is a one-cycle pulse, raised once per completed frame after its last high half.
- R9: If cont is high at the end of a frame and no stop arrived during that frame, cs_n stays low and the next frame begins at once. The next frame's low half starts on the following clock, and chan is sampled at that boundary.
- R10: A stop pulse during a frame lets that frame complete, then raises cs_n even with cont high.
- R11: A start pulse while busy is ignored. The channel in flight and the frame count are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, taken only while idle |
| cont | input | 1 | Keep running frames back to back |
| stop | input | 1 | End the run after the current frame |
| chan | input | 3 | Channel to address |
| div_half | input | 8 | System clocks per serial half period (0 acts as 1) |
| ret | input | 1 | Serial return line from the converter |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idles high |
| cmd | output | 1 | Serial command line |
| busy | output | 1 | A frame is in progress |
| res_valid | output | 1 | Result strobe |
| res_data | output | 12 | Returned conversion |
| res_chan | output | 3 | Channel the result belongs to |
| frame_err | output | 1 | Leading reply bits were not all zero |

## Verification
Single frames are tried with divider values 0, 1 and random values up to 9, with random channels. These separate correct half-period counting from off-by-one timing, and show whether the zero divider is clamped to one. Reply words with random data and an occasional nonzero leading nibble separate data alignment from the framing check. Back-to-back bursts, ended either by a stop pulse or by dropping cont, with the channel changed between frames, expose any mistake in the one-frame result tagging and in the gapless frame handover. A start pulse sent in the middle of a frame shows whether a busy request is really ignored.

// File: rtl/adc_fm_pkg.sv
package adc_fm_pkg;

  // Effective half period: a zero divider setting behaves as one.
  function automatic int unsigned half_len(input int unsigned div);
    return (div == 0) ? 1 : div;
  endfunction

  // Serial cycles in one frame: leading marker bits plus the data bits.
  function automatic int unsigned frame_len(input int unsigned lead, input int unsigned data);
    return lead + data;
  endfunction

endpackage

// File: rtl/adc_fm_div.sv
module adc_fm_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             tick
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == half - ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                 cnt <= cnt + ONE;
  end

  assert_cnt_in_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < half));
  assert_half_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (half != '0));
endmodule

// File: rtl/adc_fm_ctrl.sv
module adc_fm_ctrl
  import adc_fm_pkg::*;
#(
  parameter int CH_W      = 3,
  parameter int DIV_W     = 8,
  parameter int FRAME_LEN = 16,
  parameter int ADDR_POS  = 2,
  parameter int CNT_W     = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cont,
  input  logic             stop,
  input  logic [CH_W-1:0]  chan,
  input  logic [DIV_W-1:0] div_in,
  input  logic             tick,
  output logic             cs_n,
  output logic             sclk,
  output logic             cmd,
  output logic             run,
  output logic [DIV_W-1:0] half_q,
  output logic             sample,
  output logic             frame_end,
  output logic [CH_W-1:0]  tag
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] ONE_IDX  = CNT_W'(1);

  logic [CNT_W-1:0] bit_idx;
  logic [CH_W-1:0]  chan_q;
  logic [CH_W-1:0]  prev_chan;
  logic             stop_req;
  logic             last_bit;
  logic             keep_on;

  // Command bit for a serial cycle: channel MSB first in the address window.
  function automatic logic cmd_bit(input int unsigned idx, input logic [CH_W-1:0] ch);
    logic [CH_W-1:0] shifted;
    int unsigned k;
    if (idx >= ADDR_POS && idx < ADDR_POS + CH_W) begin
      k = idx - ADDR_POS;
      shifted = ch << k;
      return shifted[CH_W-1];
    end
    return 1'b0;
  endfunction

  assign run       = !cs_n;
  assign last_bit  = (bit_idx == LAST_IDX);
  assign sample    = tick && !sclk;
  assign frame_end = tick && sclk && last_bit;
  assign keep_on   = cont && !stop && !stop_req;
  assign tag       = prev_chan;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n      <= 1'b1;
      sclk      <= 1'b1;
      cmd       <= 1'b0;
      bit_idx   <= '0;
      chan_q    <= '0;
      prev_chan <= '0;
      half_q    <= DIV_W'(1);
      stop_req  <= 1'b0;
    end else if (cs_n) begin
      if (start) begin
        cs_n     <= 1'b0;
        sclk     <= 1'b0;
        bit_idx  <= '0;
        chan_q   <= chan;
        half_q   <= DIV_W'(half_len(32'(div_in)));
        stop_req <= 1'b0;
        cmd      <= cmd_bit(0, chan);
      end
    end else begin
      if (stop) stop_req <= 1'b1;
      if (tick) begin
        if (!sclk) begin
          sclk <= 1'b1;
        end else if (last_bit) begin
          prev_chan <= chan_q;
          bit_idx   <= '0;
          if (keep_on) begin
            sclk   <= 1'b0;
            chan_q <= chan;
            cmd    <= cmd_bit(0, chan);
          end else begin
            cs_n     <= 1'b1;
            cmd      <= 1'b0;
            stop_req <= 1'b0;
          end
        end else begin
          sclk    <= 1'b0;
          bit_idx <= bit_idx + ONE_IDX;
          cmd     <= cmd_bit(32'(bit_idx) + 1, chan_q);
        end
      end
    end
  end

  assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (sclk && !cmd));
  assert_cs_rise_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> ($past(sclk) && $past(bit_idx) == LAST_IDX));
  assert_cmd_steady_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && sclk) |-> $stable(cmd));
  assert_cmd_zero_outside_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && (32'(bit_idx) < ADDR_POS || 32'(bit_idx) >= ADDR_POS + CH_W)) |-> !cmd);
  assert_gapless_next_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && keep_on) |=> (!cs_n && !sclk));
  assert_stop_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && stop_req) |=> cs_n);
  assert_chan_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n) && !$past(frame_end)) |-> $stable(chan_q));
endmodule

// File: rtl/adc_fm_rx.sv
module adc_fm_rx #(
  parameter int DATA_W    = 12,
  parameter int LEAD_W    = 4,
  parameter int CH_W      = 3,
  parameter int FRAME_LEN = DATA_W + LEAD_W,
  parameter int CNT_W     = $clog2(FRAME_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic              ret,
  input  logic              frame_end,
  input  logic [CH_W-1:0]   tag,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic [CH_W-1:0]   res_chan,
  output logic              frame_err
);
  localparam logic [CNT_W:0] FULL  = (CNT_W+1)'(FRAME_LEN);
  localparam logic [CNT_W:0] ONE_S = (CNT_W+1)'(1);

  logic [FRAME_LEN-1:0] sh;
  logic [CNT_W:0]       seen;

  function automatic logic lead_bad(input logic [FRAME_LEN-1:0] w);
    return |w[FRAME_LEN-1:DATA_W];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh        <= '0;
      seen      <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
      res_chan  <= '0;
      frame_err <= 1'b0;
    end else begin
      res_valid <= frame_end;
      if (sample) begin
        sh   <= {sh[FRAME_LEN-2:0], ret};
        seen <= seen + ONE_S;
      end
      if (frame_end) begin
        seen      <= '0;
        res_data  <= sh[DATA_W-1:0];
        res_chan  <= tag;
        frame_err <= lead_bad(sh);
      end
    end
  end

  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample && frame_end));
  assert_full_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> (seen == FULL));
  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
endmodule

// File: rtl/adc_frame_master.sv
module adc_frame_master
  import adc_fm_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int CH_W     = 3,
  parameter int LEAD_W   = 4,
  parameter int ADDR_POS = 2,
  parameter int DIV_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cont,
  input  logic              stop,
  input  logic [CH_W-1:0]   chan,
  input  logic [DIV_W-1:0]  div_half,
  input  logic              ret,
  output logic              cs_n,
  output logic              sclk,
  output logic              cmd,
  output logic              busy,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic [CH_W-1:0]   res_chan,
  output logic              frame_err
);
  localparam int FRAME_LEN = int'(frame_len(LEAD_W, DATA_W));
  localparam int CNT_W     = $clog2(FRAME_LEN);

  logic             run;
  logic             tick;
  logic [DIV_W-1:0] half_q;
  logic             sample;
  logic             frame_end;
  logic [CH_W-1:0]  tag;

  adc_fm_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .half(half_q), .tick(tick)
  );

  adc_fm_ctrl #(
    .CH_W(CH_W), .DIV_W(DIV_W), .FRAME_LEN(FRAME_LEN),
    .ADDR_POS(ADDR_POS), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .cont(cont), .stop(stop),
    .chan(chan), .div_in(div_half), .tick(tick), .cs_n(cs_n), .sclk(sclk),
    .cmd(cmd), .run(run), .half_q(half_q), .sample(sample),
    .frame_end(frame_end), .tag(tag)
  );

  adc_fm_rx #(
    .DATA_W(DATA_W), .LEAD_W(LEAD_W), .CH_W(CH_W),
    .FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)
  ) u_rx (
    .clk(clk), .rst_n(rst_n), .sample(sample), .ret(ret),
    .frame_end(frame_end), .tag(tag), .res_valid(res_valid),
    .res_data(res_data), .res_chan(res_chan), .frame_err(frame_err)
  );

  assign busy = run;

  assert_busy_tracks_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy != cs_n);
endmodule

// File: tb/adc_frame_master_bench.sv
module adc_frame_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, cont = 1'b0, stop = 1'b0;
  logic [2:0]  chan = 3'd0;
  logic [7:0]  div_in = 8'd4;
  logic        ret;
  logic        cs_n, sclk, cmd, busy, res_valid, frame_err;
  logic [11:0] res_data;
  logic [2:0]  res_chan;

  always #5 clk = ~clk;

  adc_frame_master u_adc_frame_master (
    .clk(clk), .rst_n(rst_n), .start(start), .cont(cont), .stop(stop),
    .chan(chan), .div_half(div_in), .ret(ret), .cs_n(cs_n), .sclk(sclk),
    .cmd(cmd), .busy(busy), .res_valid(res_valid), .res_data(res_data),
    .res_chan(res_chan), .frame_err(frame_err)
  );

  // Stimulus-side state
  int         st_cmp = 0, st_bad = 0;
  int         cur_half = 4;
  logic [3:0] err_nib = 4'h0;
  logic [2:0] exp_addr [0:255];

  // Monitor / converter-model state
  int          mon_cmp = 0, mon_bad = 0;
  logic [15:0] word_cur = 16'h0;
  logic [3:0]  sl_cnt = 4'd0;
  logic [15:0] rx_sh = 16'h0;
  int          sl_frames = 0, ridx = 0, cs_rises = 0, run_len = 0;
  logic [2:0]  sl_prev_addr = 3'd0;
  logic        prev_cs = 1'b1, prev_sclk = 1'b1, prev_valid = 1'b0;
  logic [15:0] exp_word [0:255];
  logic [2:0]  exp_tag [0:255];

  assign ret = cs_n ? 1'b0 : word_cur[4'd15 - sl_cnt];

  function automatic int exp_half(input int d);
    return (d == 0) ? 1 : d;
  endfunction

  function automatic logic [15:0] mk_word();
    return {err_nib, 12'($urandom)};
  endfunction

  task automatic scheck(input bit ok, input string req, input int act, input int exp);
    st_cmp++;
    if (!ok) begin
      st_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic mcheck(input bit ok, input string req, input int act, input int exp);
    mon_cmp++;
    if (!ok) begin
      mon_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Converter model plus output monitor, all at the falling system clock edge.
  always @(negedge clk) begin
    if (res_valid) begin
      mcheck(res_data == exp_word[ridx][11:0], "R5 res_data", int'(res_data), int'(exp_word[ridx][11:0]));
      mcheck(frame_err == (|exp_word[ridx][15:12]), "R6 frame_err", int'(frame_err), int'(|exp_word[ridx][15:12]));
      mcheck(res_chan == exp_tag[ridx], "R7 res_chan", int'(res_chan), int'(exp_tag[ridx]));
      mcheck(!prev_valid, "R8 valid pulse width", int'(prev_valid), 0);
      ridx++;
    end
    if (prev_cs && !cs_n) begin
      sl_cnt   = 4'd0;
      word_cur = mk_word();
    end else if (!cs_n && !prev_sclk && sclk) begin
      rx_sh  = {rx_sh[14:0], cmd};
      sl_cnt = sl_cnt + 4'd1;
      if (sl_cnt == 4'd0) begin
        exp_word[sl_frames] = word_cur;
        exp_tag[sl_frames]  = sl_prev_addr;
        mcheck(rx_sh[13:11] == exp_addr[sl_frames], "R4 address bits", int'(rx_sh[13:11]), int'(exp_addr[sl_frames]));
        mcheck((rx_sh & 16'hC7FF) == 16'h0, "R4 idle command bits", int'(rx_sh & 16'hC7FF), 0);
        sl_prev_addr = rx_sh[13:11];
        sl_frames++;
        word_cur = mk_word();
      end
    end
    if (cs_n) run_len = 0;
    else if (run_len == 0) run_len = 1;
    else if (sclk != prev_sclk) begin
      mcheck(run_len == cur_half, "R3 half period", run_len, cur_half);
      run_len = 1;
    end else run_len++;
    if (!prev_cs && cs_n) cs_rises++;
    prev_cs    = cs_n;
    prev_sclk  = sclk;
    prev_valid = res_valid;
  end

  task automatic wait_idle();
    while (!cs_n) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic single_frame(input logic [2:0] ch, input logic [7:0] d);
    @(negedge clk);
    chan = ch; div_in = d; cur_half = exp_half(int'(d));
    exp_addr[sl_frames] = ch;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
  endtask

  task automatic burst(input int n, input logic [7:0] d, input bit by_stop);
    int base, rises0;
    logic [2:0] ch;
    base = sl_frames; rises0 = cs_rises;
    @(negedge clk);
    ch = 3'($urandom);
    chan = ch; div_in = d; cur_half = exp_half(int'(d)); cont = 1'b1;
    exp_addr[base] = ch;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k < n; k++) begin
      while (sl_frames != base + k) @(negedge clk);
      ch = 3'($urandom);
      chan = ch;
      exp_addr[base + k] = ch;
    end
    if (by_stop) begin
      repeat (2 * cur_half + 1) @(negedge clk);
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
    end else begin
      while (sl_frames != base + n) @(negedge clk);
      cont = 1'b0;
    end
    wait_idle();
    cont = 1'b0;
    scheck(sl_frames == base + n, by_stop ? "R10 frames before stop" : "R9 frames before cont drop", sl_frames - base, n);
    scheck(cs_rises == rises0 + 1, "R9 cs_n held low across frames", cs_rises - rises0, 1);
  endtask

  initial begin
    int f0, r0, rv;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    scheck(cs_n == 1'b1, "R1 cs_n idle", int'(cs_n), 1);
    scheck(sclk == 1'b1, "R1 sclk idle", int'(sclk), 1);
    scheck(cmd == 1'b0, "R1 cmd idle", int'(cmd), 0);
    scheck(busy == 1'b0, "R1 busy idle", int'(busy), 0);
    scheck(res_valid == 1'b0, "R1 res_valid idle", int'(res_valid), 0);

    // Directed single frame, first after reset (tag 0)
    err_nib = 4'h0;
    f0 = sl_frames; r0 = cs_rises;
    single_frame(3'd5, 8'd7);
    scheck(sl_frames == f0 + 1, "R2 one frame of 16 clocks", sl_frames - f0, 1);
    scheck(cs_rises == r0 + 1, "R2 cs_n returns high", cs_rises - r0, 1);
    scheck(busy == 1'b0, "R2 busy low after frame", int'(busy), 0);
    scheck(ridx == sl_frames, "R8 one result per frame", ridx, sl_frames);

    // Framing-error replies
    err_nib = 4'h8; single_frame(3'd2, 8'd3);
    err_nib = 4'h1; single_frame(3'd6, 8'd2);
    err_nib = 4'h0;

    // Divider corners
    single_frame(3'd7, 8'd0);
    single_frame(3'd0, 8'd1);

    // Start while busy is ignored (R11)
    f0 = sl_frames; r0 = cs_rises;
    @(negedge clk);
    chan = 3'd3; div_in = 8'd4; cur_half = 4;
    exp_addr[sl_frames] = 3'd3;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    chan = 3'd6; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    scheck(sl_frames == f0 + 1, "R11 busy start adds no frame", sl_frames - f0, 1);
    scheck(cs_rises == r0 + 1, "R11 busy start keeps one cs_n window", cs_rises - r0, 1);

    // Directed continuous runs
    burst(3, 8'd4, 1'b1);
    burst(2, 8'd3, 1'b0);

    // Constrained random mix
    for (int i = 0; i < 30; i++) begin
      rv = int'($urandom);
      err_nib = (rv[7:5] == 3'd0) ? (4'(rv[11:8]) | 4'h1) : 4'h0;
      if (rv[1:0] == 2'd0) burst(2 + int'(rv[13:12]) % 3, 8'(3 + rv[18:16]), rv[20]);
      else single_frame(3'(rv[24:22]), 8'(int'(rv[29:26]) % 10));
    end
    err_nib = 4'h0;
    repeat (10) @(negedge clk);
    scheck(ridx == sl_frames, "R8 results match frames", ridx, sl_frames);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", st_cmp + mon_cmp, st_bad + mon_bad);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    $display("FAIL R2 watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", st_cmp + mon_cmp + 1, st_bad + mon_bad + 1);
    $finish;
  end
endmodule